// File: doc/BRIEF.md
# DMA Page Register and Transfer Strobe Sequencer

This block sits next to a DMA controller that produces only a 16-bit memory address on an 8-bit bus with a 20-bit memory space. It keeps one small page register per DMA channel. The processor loads these registers through an I/O write. When the block runs a DMA cycle, it joins the active channel's page value to the controller's 16-bit address to form the full 20-bit memory address.

When a channel requests service, the block asks the processor for the bus and waits for the grant. It then drives the address for one clock and pulls the strobes low for a programmable number of clocks. A memory strobe, the opposite-direction I/O strobe and the channel's acknowledge line go low together, so data passes directly between memory and the peripheral. No I/O address is ever produced. The peripheral is selected only by its acknowledge line. The block refuses a memory-to-memory request and flags it as an error. While the processor owns the bus, the address enable is off and every strobe is high.

Top module: `dma_page_strobe`

## Requirements
- R1: Four page registers of 4 bits each, loaded when `cfgWrEn` is high, with `cfgIdx` selecting the channel (0..3) and `cfgData` giving the value; all reset to 0.
- R2: While `addrOe` is high, `memAddr[19:16]` holds the page of the serviced channel and `memAddr[15:0]` holds the value of `ctlAddr` captured in the clock where the grant was seen. The value stays constant until `addrOe` falls.
- R3: Mode `xferMode`=2'b00 (memory to I/O) pulls `memRdN`, `ioWrN` and the channel's `dackN` bit low together. Mode 2'b01 (I/O to memory) pulls `ioRdN`, `memWrN` and the channel's `dackN` bit low together. The other two strobes stay high, and there is no I/O address output.
- R4: A request made with mode 2'b10 (memory to memory) or 2'b11 raises `modeErr` one clock later. No hold request and no strobe are produced while it persists.
- R5: `holdReq` rises one clock after a legal request is seen with no cycle running. The address phase lasts one clock, with `addrOe` high and all strobes high, and comes before any strobe falls.
- R6: The strobes stay low for max(`strobeLen`, 2) clocks. One release clock follows, with the strobes high and `addrOe` still high, and then the bus returns to the processor.
- R7: When several `dreq` bits are high, the lowest-numbered channel is served. At most one `dackN` bit is ever low.
- R8: `holdReq` stays high from the request until the release clock ends. The address phase begins only on the clock after `holdAck` is seen high. Until then `addrOe` stays low and the strobes stay high.
- R9: While `holdReq` is low, `addrOe` is 0, `memAddr` is 0 and all strobes and `dackN` bits are high.
- R10: A page write made while a DMA cycle runs does not change the address of that cycle. It takes effect once the bus is back with the processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Processor page-register write strobe |
| cfgIdx | input | 2 | Channel index of the page write |
| cfgData | input | 4 | Page value to write |
| dreq | input | 4 | Per-channel service requests |
| xferMode | input | 2 | Transfer direction code |
| ctlAddr | input | 16 | Low address from the DMA controller |
| strobeLen | input | 4 | Strobe-low length in clocks (minimum 2 applied) |
| holdAck | input | 1 | Bus grant from the processor |
| holdReq | output | 1 | Bus request to the processor |
| modeErr | output | 1 | Illegal transfer mode flag |
| addrOe | output | 1 | Address drive enable (0 = high impedance) |
| memAddr | output | 20 | Full memory address |
| memRdN | output | 1 | Memory read strobe, active low |
| memWrN | output | 1 | Memory write strobe, active low |
| ioRdN | output | 1 | I/O read strobe, active low |
| ioWrN | output | 1 | I/O write strobe, active low |
| dackN | output | 4 | Per-channel acknowledge, active low |

## Verification
The assertions check on every clock the properties that concern a single cycle. These are: the acknowledge lines are one-hot, the strobes pair correctly for each direction, the address is driven before a strobe falls, the strobe pulse has its minimum width, the bus stays quiet with no hold and after an illegal mode, and the address stays stable. The bench scenarios are needed for the rest: the exact page and low address that appear for each channel, the strobe length for each `strobeLen`, grant delays of different lengths, which channel wins among simultaneous requests, and when a deferred page write takes effect. These require knowing the values that were written earlier.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;

  typedef enum logic [1:0] {
    MODE_M2IO = 2'b00,
    MODE_IO2M = 2'b01,
    MODE_M2M  = 2'b10,
    MODE_RSV  = 2'b11
  } xferMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_GRANT,
    ST_ADDR,
    ST_STROBE,
    ST_RELEASE
  } dmaState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic      cpuOwns;   // bus belongs to the processor
    logic      capAddr;   // capture controller low address
    logic      addrEn;    // drive the address
    logic      strobeOn;  // data phase active
    xferMode_e mode;      // latched direction
  } ctlStb_t;

endpackage

// File: rtl/dma_pg_ctrl.sv
module dma_pg_ctrl
  import dma_pg_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int LEN_W   = 4,
  parameter int MIN_LEN = 2,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] dreq,
  input  xferMode_e         xferMode,
  input  logic [LEN_W-1:0]  strobeLen,
  input  logic              holdAck,
  output logic              holdReq,
  output logic              modeErr,
  output logic [CH_W-1:0]   chSel,
  output ctlStb_t           stb
);

  dmaState_e        state;
  logic [CH_W-1:0]  pickCh;
  logic [LEN_W-1:0] effLen;
  logic [LEN_W-1:0] cnt;
  xferMode_e        modeReg;
  logic             legalMode;
  logic             anyReq;

  // fixed priority: lowest index wins
  always_comb begin
    pickCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (dreq[i]) pickCh = CH_W'(i);
    end
  end

  assign anyReq    = |dreq;
  assign legalMode = (xferMode == MODE_M2IO) || (xferMode == MODE_IO2M);
  assign effLen    = (strobeLen < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : strobeLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      chSel   <= '0;
      modeReg <= MODE_M2IO;
      cnt     <= '0;
      modeErr <= 1'b0;
    end else begin
      modeErr <= (state == ST_IDLE) && anyReq && !legalMode;
      unique case (state)
        ST_IDLE: begin
          if (anyReq && legalMode) begin
            chSel   <= pickCh;
            modeReg <= xferMode;
            state   <= ST_REQ;
          end
        end
        ST_REQ:   state <= ST_GRANT;
        ST_GRANT: if (holdAck) state <= ST_ADDR;
        ST_ADDR: begin
          cnt   <= effLen - LEN_W'(1);
          state <= ST_STROBE;
        end
        ST_STROBE: begin
          if (cnt == '0) state <= ST_RELEASE;
          else           cnt   <= cnt - LEN_W'(1);
        end
        ST_RELEASE: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign holdReq      = (state != ST_IDLE);
  assign stb.cpuOwns  = (state == ST_IDLE);
  assign stb.capAddr  = (state == ST_GRANT) && holdAck;
  assign stb.addrEn   = (state == ST_ADDR) || (state == ST_STROBE) || (state == ST_RELEASE);
  assign stb.strobeOn = (state == ST_STROBE);
  assign stb.mode     = modeReg;

  // R6: a data phase never lasts a single clock
  p_strobe_min_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.strobeOn) |=> stb.strobeOn);

  // R8: the bus request only drops after the release clock
  p_hold_through_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdReq) |-> $past(state == ST_RELEASE));

  // R8: no address phase without a seen grant
  p_wait_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GRANT && !holdAck) |=> !stb.addrEn);

endmodule

// File: rtl/dma_pg_dpath.sv
module dma_pg_dpath
  import dma_pg_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int PAGE_W  = 4,
  parameter int LOW_W   = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = PAGE_W + LOW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CH_W-1:0]   cfgIdx,
  input  logic [PAGE_W-1:0] cfgData,
  input  logic [LOW_W-1:0]  ctlAddr,
  input  ctlStb_t           stb,
  input  logic [CH_W-1:0]   chSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic              addrOe,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic [NUM_CH-1:0] dackN
);

  logic [PAGE_W-1:0] pageReg [NUM_CH];
  logic              pendValid;
  logic [CH_W-1:0]   pendIdx;
  logic [PAGE_W-1:0] pendData;
  logic [LOW_W-1:0]  lowAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) pageReg[i] <= '0;
      pendValid <= 1'b0;
      pendIdx   <= '0;
      pendData  <= '0;
      lowAddr   <= '0;
    end else begin
      if (stb.capAddr) lowAddr <= ctlAddr;
      if (stb.cpuOwns) begin
        if (pendValid) pageReg[pendIdx] <= pendData;
        pendValid <= 1'b0;
        if (cfgWrEn) pageReg[cfgIdx] <= cfgData;   // newest write wins
      end else if (cfgWrEn) begin
        pendValid <= 1'b1;
        pendIdx   <= cfgIdx;
        pendData  <= cfgData;
      end
    end
  end

  assign addrOe  = stb.addrEn;
  assign memAddr = stb.addrEn ? {pageReg[chSel], lowAddr} : '0;

  assign memRdN = !(stb.strobeOn && stb.mode == MODE_M2IO);
  assign ioWrN  = !(stb.strobeOn && stb.mode == MODE_M2IO);
  assign ioRdN  = !(stb.strobeOn && stb.mode == MODE_IO2M);
  assign memWrN = !(stb.strobeOn && stb.mode == MODE_IO2M);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dack
    assign dackN[g] = !(stb.strobeOn && chSel == CH_W'(g));
  end

  // R7: one acknowledge at a time
  p_dack_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~dackN));

  // R3: direction pairs
  p_pair_rd_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memRdN |-> (!ioWrN && memWrN && ioRdN && !(&dackN)));
  p_pair_wr_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memWrN |-> (!ioRdN && memRdN && ioWrN && !(&dackN)));

  // R5: address is on the bus before a strobe falls
  p_addr_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memRdN) || $fell(memWrN)) |-> $past(addrOe));

  // R2: address stable while driven
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addrOe && $past(addrOe)) |-> $stable(memAddr));

endmodule

// File: rtl/dma_page_strobe.sv
module dma_page_strobe
  import dma_pg_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int PAGE_W  = 4,
  parameter int LOW_W   = 16,
  parameter int LEN_W   = 4,
  parameter int MIN_LEN = 2,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = PAGE_W + LOW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CH_W-1:0]   cfgIdx,
  input  logic [PAGE_W-1:0] cfgData,
  input  logic [NUM_CH-1:0] dreq,
  input  logic [1:0]        xferMode,
  input  logic [LOW_W-1:0]  ctlAddr,
  input  logic [LEN_W-1:0]  strobeLen,
  input  logic              holdAck,
  output logic              holdReq,
  output logic              modeErr,
  output logic              addrOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic [NUM_CH-1:0] dackN
);

  ctlStb_t         stb;
  logic [CH_W-1:0] chSel;

  dma_pg_ctrl #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .dreq(dreq), .xferMode(xferMode_e'(xferMode)),
    .strobeLen(strobeLen), .holdAck(holdAck), .holdReq(holdReq),
    .modeErr(modeErr), .chSel(chSel), .stb(stb)
  );

  dma_pg_dpath #(.NUM_CH(NUM_CH), .PAGE_W(PAGE_W), .LOW_W(LOW_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .ctlAddr(ctlAddr), .stb(stb), .chSel(chSel), .memAddr(memAddr), .addrOe(addrOe),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN), .dackN(dackN)
  );

  // R9: processor owns a quiet bus
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !holdReq |-> (!addrOe && memRdN && memWrN && ioRdN && ioWrN && (&dackN)));

  // R4: an illegal mode produces no bus activity
  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> (!holdReq && (&dackN) && memRdN && memWrN));

endmodule

// File: tb/sim_dma_page_strobe.sv
module sim_dma_page_strobe;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [3:0]  cfgData = '0;
  logic [3:0]  dreq = '0;
  logic [1:0]  xferMode = '0;
  logic [15:0] ctlAddr = '0;
  logic [3:0]  strobeLen = '0;
  logic        holdAck = 1'b0;
  logic        holdReq, modeErr, addrOe, memRdN, memWrN, ioRdN, ioWrN;
  logic [19:0] memAddr;
  logic [3:0]  dackN;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [3:0] pgModel [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_page_strobe u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .dreq(dreq), .xferMode(xferMode), .ctlAddr(ctlAddr), .strobeLen(strobeLen),
    .holdAck(holdAck), .holdReq(holdReq), .modeErr(modeErr), .addrOe(addrOe),
    .memAddr(memAddr), .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN),
    .ioWrN(ioWrN), .dackN(dackN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe vector {memRdN,memWrN,ioRdN,ioWrN,dackN}
  function automatic logic [7:0] expStb(input logic [1:0] mode, input int ch, input bit on);
    logic [3:0] dk = 4'hF;
    if (!on) return 8'hFF;
    dk[ch] = 1'b0;
    return {!(mode == 2'b00), !(mode == 2'b01), !(mode == 2'b01), !(mode == 2'b00), dk};
  endfunction

  function automatic int lowestCh(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic int effLen(input logic [3:0] l);
    return (l < 2) ? 2 : int'(l);
  endfunction

  task automatic cpuWrite(input logic [1:0] idx, input logic [3:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = idx; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    pgModel[idx] = d;
  endtask

  task automatic runCycle(input logic [3:0] rq, input logic [1:0] mode, input logic [15:0] a,
                          input logic [3:0] len, input int ackDly, input bit midWrite,
                          input logic [3:0] midData);
    int ch = lowestCh(rq);
    logic [19:0] expAddr;
    @(negedge clk);
    dreq = rq; xferMode = mode; ctlAddr = a; strobeLen = len;
    @(negedge clk);
    check("R5 holdReq rises", holdReq, 1);
    check("R8 no addr before grant", addrOe, 0);
    for (int k = 0; k < ackDly; k++) begin
      @(negedge clk);
      check("R8 waiting for grant", {holdReq, addrOe, expStb(0, 0, 0) == {memRdN, memWrN, ioRdN, ioWrN, dackN}}, 3'b101);
    end
    holdAck = 1'b1;
    if (ackDly == 0) begin
      @(negedge clk);
      check("R8 grant phase quiet", addrOe, 0);
    end
    @(negedge clk);
    expAddr = {pgModel[ch], a};
    ctlAddr = ~a;                       // later change must not leak in
    check("R5 addr phase enable", addrOe, 1);
    check("R2 address assembly", memAddr, expAddr);
    check("R5 strobes high in addr phase", {memRdN, memWrN, ioRdN, ioWrN, dackN}, 8'hFF);
    if (midWrite) begin
      cfgWrEn = 1'b1; cfgIdx = 2'(ch); cfgData = midData;
    end
    for (int k = 0; k < effLen(len); k++) begin
      @(negedge clk);
      cfgWrEn = 1'b0;
      dreq = '0;
      check("R3/R7 strobe pattern", {memRdN, memWrN, ioRdN, ioWrN, dackN}, expStb(mode, ch, 1));
      check("R6/R10 address held", memAddr, expAddr);
    end
    @(negedge clk);
    check("R6 release strobes high", {memRdN, memWrN, ioRdN, ioWrN, dackN}, 8'hFF);
    check("R6 release addr still driven", {addrOe, holdReq}, 2'b11);
    holdAck = 1'b0;
    @(negedge clk);
    check("R9 bus back to cpu", {holdReq, addrOe}, 2'b00);
    check("R9 address zero", memAddr, 0);
    check("R9 strobes high", {memRdN, memWrN, ioRdN, ioWrN, dackN}, 8'hFF);
    if (midWrite) pgModel[ch] = midData;
    @(negedge clk);
  endtask

  task automatic errCase(input logic [1:0] mode);
    @(negedge clk);
    dreq = 4'b0110; xferMode = mode;
    @(negedge clk);
    check("R4 modeErr raised", modeErr, 1);
    check("R4 no hold", holdReq, 0);
    @(negedge clk);
    check("R4 no strobes", {memRdN, memWrN, ioRdN, ioWrN, dackN}, 8'hFF);
    check("R4 still no hold", {holdReq, addrOe}, 2'b00);
    dreq = '0;
    @(negedge clk);
    check("R4 modeErr clears", modeErr, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) pgModel[i] = '0;
    repeat (3) @(negedge clk);
    check("R9 reset quiet", {holdReq, addrOe, modeErr, memRdN, memWrN, ioRdN, ioWrN, dackN}, 11'b000_1111_1111);
    rstN = 1'b1;
    // R1 reset pages are zero
    runCycle(4'b0100, 2'b00, 16'h1234, 4'd3, 0, 0, 0);
    // R1 page writes per channel
    cpuWrite(0, 4'hA); cpuWrite(1, 4'h5); cpuWrite(2, 4'hF); cpuWrite(3, 4'h3);
    for (int c = 0; c < 4; c++) runCycle(4'(1 << c), 2'(c & 1), 16'hBEEF ^ 16'(c), 4'd2, c, 0, 0);
    // R6 minimum length applied for 0 and 1
    runCycle(4'b0001, 2'b01, 16'h0001, 4'd0, 1, 0, 0);
    runCycle(4'b0010, 2'b00, 16'hFFFF, 4'd1, 2, 0, 0);
    runCycle(4'b1000, 2'b01, 16'h8000, 4'd15, 0, 0, 0);
    // R7 priority among simultaneous requests
    runCycle(4'b1111, 2'b00, 16'h4444, 4'd2, 0, 0, 0);
    runCycle(4'b1100, 2'b01, 16'h5555, 4'd2, 1, 0, 0);
    // R10 deferred page write
    runCycle(4'b0010, 2'b00, 16'h0F0F, 4'd4, 1, 1, 4'h9);
    runCycle(4'b0010, 2'b01, 16'h00F0, 4'd2, 0, 0, 0);
    // R4 illegal modes
    errCase(2'b10);
    errCase(2'b11);
    // random mix
    for (int n = 0; n < 40; n++) begin
      if ($urandom % 3 == 0) cpuWrite(2'($urandom), 4'($urandom));
      runCycle(4'($urandom % 15 + 1), 2'($urandom % 2), 16'($urandom), 4'($urandom),
               int'($urandom % 4), bit'($urandom % 2), 4'($urandom));
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule